// File: doc/BRIEF.md
# Three-Channel Match Timer

This block is a memory-mapped timer with three independent 32-bit up-counters. Each counter has three compare registers, a per-counter choice of count source, an enable bit, and a choice between running freely and reloading from a preload register when a selected comparator hits. Each comparator sets a sticky status flag. Software clears these flags by writing ones. Each counter drives its own interrupt line from its status flags, masked by a per-counter enable mask.

The counter time bases are not separate clocks. They are three single-cycle strobes inside the one system clock domain: a fast rate, a 32 kHz rate and a 1 kHz rate. The enable bit reaches the counting logic through two stages that advance only on the counter's own strobe, so starting and stopping lag by two counter ticks. A new compare value written while the counter runs is parked until a restart request. A restart request then zeroes the counter and applies the parked values on the next tick of the counter's source, without a stop/start sequence. A one-shot delay of D ticks is set by loading D-1 into comparator 0.

The bus is a single-cycle write port, committed in any cycle with select, enable and write all high. Reads are combinational from the address while select is high and write is low.

Top module: `mct_timer`

## Requirements
- R1: After reset every readable register reads zero and all interrupt outputs are low.
- R2: The source register at 0x00 holds a 2-bit field per counter, in bits [1:0], [3:2] and [6:5] for counters 0, 1 and 2. The codes are: counter 0: 0 fast, 1 32 kHz. Counter 1: 0 fast, 1 32 kHz, 2 1 kHz. Counter 2: 0 fast, 1 1 kHz, 2 32 kHz. Any other code selects no source, and the counter stops.
- R3: Bit n of the enable register at 0x84 runs counter n. After it is set, the counter first increments on the third tick of its source. After it is cleared, exactly two more increments occur.
- R4: Comparator m of counter n sets status bit m (status register at 0x34+4n) when a counting tick arrives while the counter equals that comparator's active value. Loading D-1 therefore flags after D counted ticks.
- R5: Interrupt n is high exactly when some status bit of counter n is set whose bit is also set in its mask register at 0x40+4n.
- R6: Writing the clear register at 0x74+4n clears each status bit written as 1 and leaves bits written as 0 unchanged. Writing 0x7 clears all three bits.
- R7: When bit n of the mode register at 0x88 is 0 and the preload control at 0x58+4n holds k in 1..3, a counting tick that hits comparator k-1 loads the preload value (0x4C+4n) instead of incrementing.
- R8: The counter wraps freely past every comparator when its mode bit is 1 or its preload control is 0.
- R9: The compare register for counter n, comparator m, is at 0x04+8n+4(n+m) and reads back the last value written. The write becomes active at once if the counter is stopped and its enable stages are empty. Otherwise it waits for a restart.
- R10: Writing 1 to bit n of the restart register at 0xB0 sets that bit, and the bit reads as 1. On the next tick of counter n's source the counter (read at 0x28+4n) becomes 0, the waiting compare values become active, and the bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_en | input | 1 | Access phase strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| tick_fast | input | 1 | Fast-rate count strobe |
| tick_slow | input | 1 | 32 kHz count strobe |
| tick_milli | input | 1 | 1 kHz count strobe |
| irq | output | 3 | Interrupt per counter |

## Verification
The hardest state to reach is a compare value that has been written but is not yet active while the counter runs. Only a counter value that passes the new compare value without flagging, and then flags on it after a restart, shows this state. The stimulus starts a counter and lets it run past a fresh compare value. It then issues the restart and counts to the parked value. A preload case with comparator 2 repeats the pattern. The source decode is covered with random tick counts of each rate, applied one rate at a time. Each counter and code is reached after a restart and two priming ticks, so the enable delay is known.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [1:0] {
    SRC_FAST  = 2'd0,
    SRC_SLOW  = 2'd1,
    SRC_MILLI = 2'd2,
    SRC_NONE  = 2'd3
  } src_e;

  localparam logic [7:0] A_SRC   = 8'h00;
  localparam logic [7:0] A_CNT   = 8'h28;
  localparam logic [7:0] A_STS   = 8'h34;
  localparam logic [7:0] A_MASK  = 8'h40;
  localparam logic [7:0] A_PLV   = 8'h4C;
  localparam logic [7:0] A_PLC   = 8'h58;
  localparam logic [7:0] A_CLR   = 8'h74;
  localparam logic [7:0] A_RUN   = 8'h84;
  localparam logic [7:0] A_MODE  = 8'h88;
  localparam logic [7:0] A_RESTART = 8'hB0;

  // Compare register placement is decoded by software, so it is kept.
  function automatic logic [7:0] cmp_addr(int n, int m);
    return 8'(4 + 8 * n + 4 * (n + m));
  endfunction

  function automatic logic [7:0] bank_addr(logic [7:0] base, int n);
    return base + 8'(4 * n);
  endfunction

  // Lowest bit of each counter's source field; counter 2 skips bit 4.
  function automatic int src_lsb(int n);
    return (n == 2) ? 5 : 2 * n;
  endfunction

  function automatic src_e decode_src(int n, logic [1:0] code);
    src_e s;
    s = SRC_NONE;
    case (n)
      0: case (code)
           2'd0: s = SRC_FAST;
           2'd1: s = SRC_SLOW;
           default: s = SRC_NONE;
         endcase
      1: case (code)
           2'd0: s = SRC_FAST;
           2'd1: s = SRC_SLOW;
           2'd2: s = SRC_MILLI;
           default: s = SRC_NONE;
         endcase
      default: case (code)
           2'd0: s = SRC_FAST;
           2'd1: s = SRC_MILLI;
           2'd2: s = SRC_SLOW;
           default: s = SRC_NONE;
         endcase
    endcase
    return s;
  endfunction

endpackage

// File: rtl/mct_tick_sel.sv
module mct_tick_sel
  import mct_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [1:0] code,
  input  logic       tick_fast,
  input  logic       tick_slow,
  input  logic       tick_milli,
  output logic       tick
);

  src_e src;

  always_comb begin
    src = decode_src(IDX, code);
    case (src)
      SRC_FAST:  tick = tick_fast;
      SRC_SLOW:  tick = tick_slow;
      SRC_MILLI: tick = tick_milli;
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int W      = 32,
  parameter int NCMP   = 3,
  parameter int PLC_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      enable,
  input  logic                      free_run,
  input  logic [W-1:0]              wdata,
  input  logic [NCMP-1:0]           wr_cmp,
  input  logic                      wr_mask,
  input  logic                      wr_plv,
  input  logic                      wr_plc,
  input  logic                      wr_clr,
  input  logic                      wr_restart,
  output logic [W-1:0]              cnt_o,
  output logic [NCMP-1:0][W-1:0]    cmp_pend_o,
  output logic [NCMP-1:0]           sts_o,
  output logic [NCMP-1:0]           mask_o,
  output logic [W-1:0]              plv_o,
  output logic [PLC_W-1:0]          plc_o,
  output logic                      busy_o,
  output logic                      irq_o
);

  logic [1:0]             run_q, run_d;
  logic [W-1:0]           cnt_q, cnt_d;
  logic [NCMP-1:0][W-1:0] pend_q, pend_d;
  logic [NCMP-1:0][W-1:0] act_q, act_d;
  logic [NCMP-1:0]        sts_q, sts_d;
  logic [NCMP-1:0]        mask_q, mask_d;
  logic [W-1:0]           plv_q, plv_d;
  logic [PLC_W-1:0]       plc_q, plc_d;
  logic                   busy_q, busy_d;

  logic                   done, step, idle, rl_hit, reload;
  logic [NCMP-1:0]        hit;

  always_comb begin
    done = busy_q & tick;
    step = tick & run_q[1] & ~done;
    idle = ~enable & ~run_q[0] & ~run_q[1];

    for (int m = 0; m < NCMP; m++) begin
      hit[m] = step & (cnt_q == act_q[m]);
    end

    rl_hit = 1'b0;
    for (int m = 0; m < NCMP; m++) begin
      if (plc_q == PLC_W'(m + 1)) rl_hit = hit[m];
    end
    reload = ~free_run & rl_hit;

    // two-stage enable, advanced only by the counter's own tick
    run_d = tick ? {run_q[0], enable} : run_q;

    if (done)        cnt_d = '0;
    else if (reload) cnt_d = plv_q;
    else if (step)   cnt_d = cnt_q + W'(1);
    else             cnt_d = cnt_q;

    for (int m = 0; m < NCMP; m++) begin
      pend_d[m] = wr_cmp[m] ? wdata : pend_q[m];
      if (done)                    act_d[m] = pend_d[m];
      else if (wr_cmp[m] && idle)  act_d[m] = wdata;
      else                         act_d[m] = act_q[m];
    end

    sts_d  = (sts_q & ~(wr_clr ? wdata[NCMP-1:0] : '0)) | hit;
    mask_d = wr_mask ? wdata[NCMP-1:0] : mask_q;
    plv_d  = wr_plv ? wdata : plv_q;
    plc_d  = wr_plc ? wdata[PLC_W-1:0] : plc_q;

    if (done)                       busy_d = 1'b0;
    else if (wr_restart && !busy_q) busy_d = 1'b1;
    else                            busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      act_q  <= '0;
      sts_q  <= '0;
      mask_q <= '0;
      plv_q  <= '0;
      plc_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      sts_q  <= sts_d;
      mask_q <= mask_d;
      plv_q  <= plv_d;
      plc_q  <= plc_d;
      busy_q <= busy_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cmp_pend_o = pend_q;
  assign sts_o      = sts_q;
  assign mask_o     = mask_q;
  assign plv_o      = plv_q;
  assign plc_o      = plc_q;
  assign busy_o     = busy_q;
  assign irq_o      = |(sts_q & mask_q);

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int W    = 32,
  parameter int AW   = 8,
  parameter int NCMP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  input  logic          tick_milli,
  output logic [2:0]    irq
);

  localparam int NCNT   = 3;
  localparam int SRC_W  = src_lsb(NCNT - 1) + 2;
  localparam int PLC_W  = 2;

  logic                          wr_go;
  logic [SRC_W-1:0]              src_q, src_d;
  logic [NCNT-1:0]               run_q, run_d;
  logic [NCNT-1:0]               mode_q, mode_d;

  logic [NCNT-1:0]               tick_sel;
  logic [NCNT-1:0]               wr_mask, wr_plv, wr_plc, wr_clr, wr_restart;
  logic [NCNT-1:0][NCMP-1:0]     wr_cmp;
  logic [NCNT-1:0][W-1:0]        cnt_v, plv_v;
  logic [NCNT-1:0][NCMP-1:0][W-1:0] pend_v;
  logic [NCNT-1:0][NCMP-1:0]     sts_v, mask_v;
  logic [NCNT-1:0][PLC_W-1:0]    plc_v;
  logic [NCNT-1:0]               busy_v;

  assign wr_go = bus_sel & bus_en & bus_wr;

  always_comb begin
    src_d  = (wr_go && bus_addr == AW'(A_SRC))  ? bus_wdata[SRC_W-1:0] : src_q;
    run_d  = (wr_go && bus_addr == AW'(A_RUN))  ? bus_wdata[NCNT-1:0]  : run_q;
    mode_d = (wr_go && bus_addr == AW'(A_MODE)) ? bus_wdata[NCNT-1:0]  : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      run_q  <= '0;
      mode_q <= '0;
    end else begin
      src_q  <= src_d;
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    localparam int LSB = src_lsb(n);

    mct_tick_sel #(.IDX(n)) u_sel (
      .code       (src_q[LSB +: 2]),
      .tick_fast  (tick_fast),
      .tick_slow  (tick_slow),
      .tick_milli (tick_milli),
      .tick       (tick_sel[n])
    );

    for (genvar m = 0; m < NCMP; m++) begin : g_wcmp
      assign wr_cmp[n][m] = wr_go && (bus_addr == AW'(cmp_addr(n, m)));
    end

    assign wr_mask[n]    = wr_go && (bus_addr == AW'(bank_addr(A_MASK, n)));
    assign wr_plv[n]     = wr_go && (bus_addr == AW'(bank_addr(A_PLV, n)));
    assign wr_plc[n]     = wr_go && (bus_addr == AW'(bank_addr(A_PLC, n)));
    assign wr_clr[n]     = wr_go && (bus_addr == AW'(bank_addr(A_CLR, n)));
    assign wr_restart[n] = wr_go && (bus_addr == AW'(A_RESTART)) && bus_wdata[n];

    mct_counter #(.W(W), .NCMP(NCMP), .PLC_W(PLC_W)) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick_sel[n]),
      .enable     (run_q[n]),
      .free_run   (mode_q[n]),
      .wdata      (bus_wdata),
      .wr_cmp     (wr_cmp[n]),
      .wr_mask    (wr_mask[n]),
      .wr_plv     (wr_plv[n]),
      .wr_plc     (wr_plc[n]),
      .wr_clr     (wr_clr[n]),
      .wr_restart (wr_restart[n]),
      .cnt_o      (cnt_v[n]),
      .cmp_pend_o (pend_v[n]),
      .sts_o      (sts_v[n]),
      .mask_o     (mask_v[n]),
      .plv_o      (plv_v[n]),
      .plc_o      (plc_v[n]),
      .busy_o     (busy_v[n]),
      .irq_o      (irq[n])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == AW'(A_SRC))     bus_rdata = W'(src_q);
      if (bus_addr == AW'(A_RUN))     bus_rdata = W'(run_q);
      if (bus_addr == AW'(A_MODE))    bus_rdata = W'(mode_q);
      if (bus_addr == AW'(A_RESTART)) bus_rdata = W'(busy_v);
      for (int n = 0; n < NCNT; n++) begin
        if (bus_addr == AW'(bank_addr(A_CNT, n)))  bus_rdata = cnt_v[n];
        if (bus_addr == AW'(bank_addr(A_STS, n)))  bus_rdata = W'(sts_v[n]);
        if (bus_addr == AW'(bank_addr(A_MASK, n))) bus_rdata = W'(mask_v[n]);
        if (bus_addr == AW'(bank_addr(A_PLV, n)))  bus_rdata = plv_v[n];
        if (bus_addr == AW'(bank_addr(A_PLC, n)))  bus_rdata = W'(plc_v[n]);
        for (int m = 0; m < NCMP; m++) begin
          if (bus_addr == AW'(cmp_addr(n, m))) bus_rdata = pend_v[n][m];
        end
      end
    end
  end

endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int W    = 32,
  parameter int NCMP = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [2:0]                  tick_sel,
  input logic [2:0]                  busy,
  input logic [2:0]                  wr_clr,
  input logic [2:0]                  irq,
  input logic [2:0][NCMP-1:0]        sts,
  input logic [2:0][W-1:0]           cnt
);

  for (genvar n = 0; n < 3; n++) begin : g_chk
    // R10: a completed restart leaves the counter at zero
    a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[n]) |-> (cnt[n] == '0));

    // R10: a pending restart waits for the counter's tick
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy[n]) && !$past(tick_sel[n])) |-> busy[n]);

    // R2: no tick from the selected source, no change of count
    a_r2_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_sel[n]) |-> $stable(cnt[n]));

    // R5: an interrupt always has a status flag behind it
    a_r5_irq_has_status: assert property (@(posedge clk) disable iff (!rst_n)
      irq[n] |-> (sts[n] != '0));

    for (genvar m = 0; m < NCMP; m++) begin : g_sts
      // R6: status is only removed by a clear-register write
      a_r6_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sts[n][m]) && !$past(wr_clr[n])) |-> sts[n][m]);
    end
  end

endmodule

bind mct_timer mct_timer_chk #(.W(W), .NCMP(NCMP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_sel (tick_sel),
  .busy     (busy_v),
  .wr_clr   (wr_clr),
  .irq      (irq),
  .sts      (sts_v),
  .cnt      (cnt_v)
);

// File: tb/mct_timer_bench.sv
module mct_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_en, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tick_fast, tick_slow, tick_milli;
  logic [2:0]  irq;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mct_timer u_mct_timer (
    .clk (clk), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_en (bus_en), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .tick_fast (tick_fast), .tick_slow (tick_slow), .tick_milli (tick_milli),
    .irq (irq)
  );

  // register map as stated in the requirements
  function automatic logic [7:0] f_cmp(int n, int m);
    return 8'(4 + 8 * n + 4 * (n + m));
  endfunction
  function automatic logic [7:0] f_bank(int base, int n);
    return 8'(base + 4 * n);
  endfunction
  function automatic logic [31:0] f_src_word(int n, int code);
    int sh;
    sh = (n == 0) ? 0 : (n == 1) ? 2 : 5;
    return 32'(code) << sh;
  endfunction
  // 0 fast, 1 slow, 2 milli, 3 none
  function automatic int f_src(int n, int code);
    if (n == 0) return (code == 0) ? 0 : (code == 1) ? 1 : 3;
    if (n == 1) return (code == 3) ? 3 : code;
    return (code == 0) ? 0 : (code == 1) ? 2 : (code == 2) ? 1 : 3;
  endfunction
  function automatic int f_exp_count(int n, int code, int a, int b, int c);
    case (f_src(n, code))
      0: return a;
      1: return b;
      2: return c;
      default: return 0;
    endcase
  endfunction

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0; bus_en = 1'b0;
    chk(tag, d, exp);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic tk(input bit f, input bit s, input bit m, input int num);
    repeat (num) begin
      @(negedge clk);
      tick_fast = f; tick_slow = s; tick_milli = m;
    end
    @(negedge clk);
    tick_fast = 1'b0; tick_slow = 1'b0; tick_milli = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    int d_val, p_val, t_val, m_val, q_val;
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    bus_sel = 0; bus_en = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    tick_fast = 0; tick_slow = 0; tick_milli = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 source", 8'h00, 0);
    rd_chk("R1 enable", 8'h84, 0);
    rd_chk("R1 restart", 8'hB0, 0);
    for (int n = 0; n < 3; n++) begin
      rd_chk("R1 count", f_bank(8'h28, n), 0);
      rd_chk("R1 status", f_bank(8'h34, n), 0);
    end
    chk("R1 irq", 32'(irq), 0);

    // R2 source decode with random tick mixes
    wr(8'h88, 32'h7);
    for (int n = 0; n < 3; n++) begin
      for (int code = 0; code < 3; code++) begin
        int a, b, c;
        if (f_src(n, code) == 3) continue;
        a = int'($urandom_range(1, 20));
        b = int'($urandom_range(1, 20));
        c = int'($urandom_range(1, 20));
        wr(8'h84, 0);
        tk(1, 1, 1, 3);
        wr(8'h00, f_src_word(n, code));
        wr(8'hB0, 32'(1) << n);
        tk(1, 1, 1, 1);
        wr(8'h84, 32'(1) << n);
        tk(1, 1, 1, 2);
        tk(1, 0, 0, a);
        tk(0, 1, 0, b);
        tk(0, 0, 1, c);
        rd_chk("R2 source decode", f_bank(8'h28, n), 32'(f_exp_count(n, code, a, b, c)));
      end
    end
    // R2 unused code on counter 0 freezes it
    wr(8'h00, 0);
    wr(8'h84, 1);
    tk(1, 1, 1, 3);
    rd(8'h28, v);
    wr(8'h00, 32'h2);
    tk(1, 1, 1, 4);
    rd_chk("R2 unused code stops", 8'h28, v);

    // R3 enable and disable latency on counter 0
    wr(8'h00, 0);
    wr(8'h84, 0);
    tk(1, 0, 0, 3);
    wr(8'hB0, 1);
    tk(1, 0, 0, 1);
    rd_chk("R10 restart zero", 8'h28, 0);
    wr(8'h84, 1);
    tk(1, 0, 0, 5);
    rd_chk("R3 start latency", 8'h28, 3);
    wr(8'h84, 0);
    tk(1, 0, 0, 5);
    rd_chk("R3 stop latency", 8'h28, 5);

    // R9 parked compare value on counter 0
    wr(f_bank(8'h74, 0), 7);
    wr(f_cmp(0, 0), 20);
    wr(f_cmp(0, 1), 1000);
    wr(f_cmp(0, 2), 1000);
    wr(8'hB0, 1);
    tk(1, 0, 0, 1);
    wr(8'h84, 1);
    tk(1, 0, 0, 2);
    tk(1, 0, 0, 5);
    wr(f_cmp(0, 0), 8);
    rd_chk("R9 readback", f_cmp(0, 0), 8);
    tk(1, 0, 0, 5);
    rd(8'h34, v);
    chk("R9 parked value inactive", v & 1, 0);
    wr(8'hB0, 1);
    rd_chk("R10 busy readback", 8'hB0, 1);
    tk(1, 0, 0, 1);
    rd_chk("R10 busy clears", 8'hB0, 0);
    rd_chk("R10 count zero", 8'h28, 0);
    tk(1, 0, 0, 8);
    rd(8'h34, v);
    chk("R9 no early flag", v & 1, 0);
    tk(1, 0, 0, 1);
    rd(8'h34, v);
    chk("R9 applied by restart", v & 1, 1);

    // R4 R5 R6 comparators on counter 1
    d_val = int'($urandom_range(4, 30));
    wr(8'h84, 0);
    tk(1, 1, 1, 3);
    wr(f_bank(8'h74, 1), 7);
    wr(f_bank(8'h40, 1), 0);
    wr(f_cmp(1, 0), 32'(d_val - 1));
    wr(f_cmp(1, 1), 32'(d_val + 1));
    wr(f_cmp(1, 2), 32'(d_val + 3));
    wr(8'hB0, 2);
    tk(1, 0, 0, 1);
    wr(8'h84, 2);
    tk(1, 0, 0, 2);
    tk(1, 0, 0, d_val - 1);
    rd_chk("R4 not before D", f_bank(8'h34, 1), 0);
    tk(1, 0, 0, 1);
    rd_chk("R4 flag at D", f_bank(8'h34, 1), 1);
    chk("R5 masked irq", 32'(irq[1]), 0);
    wr(f_bank(8'h40, 1), 1);
    chk("R5 unmasked irq", 32'(irq[1]), 1);
    wr(f_bank(8'h74, 1), 2);
    rd_chk("R6 zero bits keep", f_bank(8'h34, 1), 1);
    wr(f_bank(8'h74, 1), 1);
    tk(1, 0, 0, 2);
    rd_chk("R4 comparator 1", f_bank(8'h34, 1), 2);
    tk(1, 0, 0, 2);
    rd_chk("R4 comparator 2", f_bank(8'h34, 1), 6);
    rd_chk("R4 count", f_bank(8'h28, 1), 32'(d_val + 4));
    chk("R5 irq off for unmasked bits", 32'(irq[1]), 0);
    wr(f_bank(8'h74, 1), 4);
    rd_chk("R6 single clear", f_bank(8'h34, 1), 2);
    wr(f_bank(8'h74, 1), 7);
    rd_chk("R6 clear all", f_bank(8'h34, 1), 0);

    // R7 R8 preload on counter 2
    p_val = int'($urandom_range(1, 8));
    t_val = int'($urandom_range(2, 6));
    m_val = p_val + t_val;
    q_val = p_val + 2;
    wr(8'h84, 0);
    tk(1, 1, 1, 3);
    wr(8'h88, 32'h3);
    wr(f_bank(8'h58, 2), 1);
    wr(f_bank(8'h4C, 2), 32'(p_val));
    wr(f_cmp(2, 0), 32'(m_val));
    wr(f_cmp(2, 1), 1000);
    wr(f_cmp(2, 2), 1000);
    wr(8'hB0, 4);
    tk(1, 0, 0, 1);
    wr(8'h84, 4);
    tk(1, 0, 0, 2);
    tk(1, 0, 0, m_val + 1);
    rd_chk("R7 reload on comparator 0", f_bank(8'h28, 2), 32'(p_val));
    tk(1, 0, 0, 1);
    rd_chk("R7 continues after reload", f_bank(8'h28, 2), 32'(p_val + 1));
    wr(8'h88, 32'h7);
    tk(1, 0, 0, t_val);
    rd_chk("R8 mode bit free runs", f_bank(8'h28, 2), 32'(m_val + 1));
    wr(8'h88, 32'h3);
    wr(f_bank(8'h58, 2), 0);
    wr(8'hB0, 4);
    rd_chk("R10 busy bit 2", 8'hB0, 4);
    tk(1, 0, 0, 1);
    tk(1, 0, 0, m_val + 2);
    rd_chk("R8 zero control free runs", f_bank(8'h28, 2), 32'(m_val + 2));
    wr(f_bank(8'h58, 2), 3);
    wr(f_cmp(2, 2), 32'(q_val));
    rd_chk("R9 readback running", f_cmp(2, 2), 32'(q_val));
    wr(8'hB0, 4);
    tk(1, 0, 0, 1);
    tk(1, 0, 0, q_val + 1);
    rd_chk("R7 reload on comparator 2", f_bank(8'h28, 2), 32'(p_val));

    summary();
  end

endmodule